// File: doc/BRIEF.md
# Address Acceptance Controller

This block sits on the write-address and read-address channels of a bus bridge and decides how many address/control entries each direction may hold at once. The limit per direction is a parameter set to 1 or 2. Accepted entries wait in a small per-direction queue, and the channel ready signals are derived from how full that queue is. A slot is released only when its oldest entry has finished two things: the transfer on the downstream bus and the response phase on the upstream side.

The downstream bus can carry only one transaction at a time and has no pipelined or secondary address phase. A single shared issuer therefore presents one request at a time. It holds the address and the direction steady until the downstream side pulses its done signal. When both directions have an entry waiting, a round-robin choice decides which one goes first. Entries of one direction go downstream in the order they were accepted, and responses are matched to entries in that same order.

Top module: `acc_ctl_top`

## Requirements
- R1: After reset, aw_ready and ar_ready are 1 and dn_req is 0.
- R2: With a limit of 1, aw_ready drops in the cycle after an address is accepted. It stays 0 after the downstream done pulse alone, and returns to 1 within three cycles once the write response handshake (b_valid and b_ready both 1) has also occurred.
- R3: With a limit of 2, a second address is accepted in the cycle right after the first, while the first is still pending.
- R4: With a limit of 2 and two entries held, ready stays 0 until the oldest entry has both completed downstream and seen its response. For reads, the response is a beat with r_valid, r_ready and r_last all 1, and a beat with r_last 0 does not count. Ready then returns to 1.
- R5: Once dn_req is 1, dn_req, dn_addr, dn_ctrl and dn_rnw stay unchanged until the cycle in which dn_done is 1.
- R6: A new downstream request starts only after every earlier request has received its dn_done pulse.
- R7: Within one direction, entries reach the downstream bus in the order they were accepted.
- R8: When both directions have an entry waiting while the bus is idle, the direction not granted most recently goes first. A read granted last means the write wins.
- R9: dn_rnw is 1 for a read entry and 0 for a write entry, and dn_addr and dn_ctrl equal the address and control fields captured at acceptance.
- R10: A response handshake that arrives when no entry is waiting for a response is ignored. A later entry still waits for its own response.
- R11: A response handshake that arrives before the downstream done pulse is remembered. The entry completes when the done pulse arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| aw_valid | input | 1 | Write address valid |
| aw_ready | output | 1 | Write address ready (queue not full) |
| aw_addr | input | ADDR_W | Write address |
| aw_ctrl | input | CTRL_W | Write control (length, size, burst) |
| ar_valid | input | 1 | Read address valid |
| ar_ready | output | 1 | Read address ready (queue not full) |
| ar_addr | input | ADDR_W | Read address |
| ar_ctrl | input | CTRL_W | Read control |
| b_valid | input | 1 | Write response valid (observed) |
| b_ready | input | 1 | Write response ready (observed) |
| r_valid | input | 1 | Read data valid (observed) |
| r_ready | input | 1 | Read data ready (observed) |
| r_last | input | 1 | Last read beat (observed) |
| dn_req | output | 1 | Downstream request active |
| dn_rnw | output | 1 | Downstream direction, 1 = read |
| dn_addr | output | ADDR_W | Downstream address |
| dn_ctrl | output | CTRL_W | Downstream control |
| dn_done | input | 1 | Downstream transfer complete pulse |

## Verification
Two functions can fall in the same cycle: accepting a write address and accepting a read address. Both entries then reach an idle downstream issuer together and must be arbitrated. The bench raises aw_valid and ar_valid on the same edge with both queues empty, once just after a read grant and once just after a lone write grant. The scoreboard logs the direction of every new downstream request and expects the opposite of the previous winner to go first, while each held request's address stays stable.

// File: rtl/acc_ctl_pkg.sv
package acc_ctl_pkg;

    typedef enum logic {
        SRC_WR = 1'b0,
        SRC_RD = 1'b1
    } src_e;

    // Position inside a ring of 'depth' slots, 'off' places after 'base'.
    function automatic int unsigned ring_add(int unsigned base, int unsigned off,
                                             int unsigned depth);
        return (base + off) % depth;
    endfunction

    // Clamp an acceptance parameter to the supported range 1..2.
    function automatic int clamp_accept(int value);
        return (value <= 1) ? 1 : 2;
    endfunction

endpackage

// File: rtl/acc_path.sv
module acc_path
    import acc_ctl_pkg::*;
#(
    parameter int DEPTH = 2,
    parameter int ENT_W = 40
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [ENT_W-1:0] in_data,
    input  logic             rsp_hs,
    output logic             pend_valid,
    output logic [ENT_W-1:0] pend_data,
    input  logic             grant,
    input  logic             fin
);

    localparam int CW = $clog2(DEPTH + 1);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [ENT_W-1:0] slots [DEPTH];
    logic [IW-1:0]    head;
    logic [CW-1:0]    occ;      // entries held
    logic [CW-1:0]    issued;   // entries sent downstream (from head)
    logic [CW-1:0]    dn_fin;   // entries whose downstream transfer finished
    logic [CW-1:0]    rsp_seen; // responses counted against held entries

    logic          push, pop, issue, rsp_ok;
    logic [IW-1:0] wr_idx, iss_idx;

    assign in_ready   = (occ < CW'(DEPTH));
    assign push       = in_valid && in_ready;
    assign pend_valid = (issued < occ);
    assign issue      = grant && pend_valid;
    assign rsp_ok     = rsp_hs && (rsp_seen < occ);
    assign pop        = (dn_fin != '0) && (rsp_seen != '0);

    assign wr_idx    = IW'(ring_add(32'(head), 32'(occ), DEPTH));
    assign iss_idx   = IW'(ring_add(32'(head), 32'(issued), DEPTH));
    assign pend_data = slots[iss_idx];

    always_ff @(posedge clk) begin
        if (push) begin
            slots[wr_idx] <= in_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            head     <= '0;
            occ      <= '0;
            issued   <= '0;
            dn_fin   <= '0;
            rsp_seen <= '0;
        end else begin
            occ      <= occ + CW'(push) - CW'(pop);
            issued   <= issued + CW'(issue) - CW'(pop);
            dn_fin   <= dn_fin + CW'(fin) - CW'(pop);
            rsp_seen <= rsp_seen + CW'(rsp_ok) - CW'(pop);
            if (pop) begin
                head <= IW'(ring_add(32'(head), 1, DEPTH));
            end
        end
    end

    // R2: ready can only drop because an entry was just taken in
    p_ready_fall_r2: assert property (@(posedge clk) disable iff (rst)
        $fell(in_ready) |-> $past(push));

    // R4: ready can only come back because the oldest entry was released
    p_ready_rise_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(in_ready) |-> $past(pop));

    // R6: no downstream completion is counted for an entry never issued
    p_done_le_issue_r6: assert property (@(posedge clk) disable iff (rst)
        dn_fin <= issued);

    // R10: responses are never counted beyond the entries held
    p_rsp_le_occ_r10: assert property (@(posedge clk) disable iff (rst)
        rsp_seen <= occ);

    // R8: a waiting entry that is not granted stays offered and unchanged
    p_pend_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (pend_valid && !grant) |=> (pend_valid && $stable(pend_data)));

endmodule

// File: rtl/acc_issue_arb.sv
module acc_issue_arb
    import acc_ctl_pkg::*;
#(
    parameter int ENT_W = 40
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_pend,
    input  logic [ENT_W-1:0] wr_data,
    input  logic             rd_pend,
    input  logic [ENT_W-1:0] rd_data,
    input  logic             dn_done,
    output logic             wr_grant,
    output logic             rd_grant,
    output logic             wr_fin,
    output logic             rd_fin,
    output logic             dn_req,
    output logic             dn_rnw,
    output logic [ENT_W-1:0] dn_ent
);

    logic busy;
    src_e owner, last_win;

    always_comb begin
        wr_grant = 1'b0;
        rd_grant = 1'b0;
        if (!busy) begin
            if (wr_pend && (!rd_pend || last_win == SRC_RD)) begin
                wr_grant = 1'b1;
            end else if (rd_pend) begin
                rd_grant = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy     <= 1'b0;
            owner    <= SRC_WR;
            last_win <= SRC_RD;
            dn_ent   <= '0;
        end else if (busy) begin
            if (dn_done) begin
                busy <= 1'b0;
            end
        end else if (wr_grant) begin
            busy     <= 1'b1;
            owner    <= SRC_WR;
            last_win <= SRC_WR;
            dn_ent   <= wr_data;
        end else if (rd_grant) begin
            busy     <= 1'b1;
            owner    <= SRC_RD;
            last_win <= SRC_RD;
            dn_ent   <= rd_data;
        end
    end

    assign dn_req = busy;
    assign dn_rnw = (owner == SRC_RD);
    assign wr_fin = busy && dn_done && (owner == SRC_WR);
    assign rd_fin = busy && dn_done && (owner == SRC_RD);

    // R5: an active downstream request holds until its done pulse
    p_req_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (dn_req && !dn_done) |=> (dn_req && $stable(dn_ent) && $stable(dn_rnw)));

    // R6: a done pulse ends the request, leaving one idle cycle
    p_gap_after_done_r6: assert property (@(posedge clk) disable iff (rst)
        (dn_req && dn_done) |=> !dn_req);

endmodule

// File: rtl/acc_ctl_top.sv
module acc_ctl_top
    import acc_ctl_pkg::*;
#(
    parameter int WR_ACCEPT = 2,
    parameter int RD_ACCEPT = 2,
    parameter int ADDR_W    = 32,
    parameter int CTRL_W    = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              aw_valid,
    output logic              aw_ready,
    input  logic [ADDR_W-1:0] aw_addr,
    input  logic [CTRL_W-1:0] aw_ctrl,
    input  logic              ar_valid,
    output logic              ar_ready,
    input  logic [ADDR_W-1:0] ar_addr,
    input  logic [CTRL_W-1:0] ar_ctrl,
    input  logic              b_valid,
    input  logic              b_ready,
    input  logic              r_valid,
    input  logic              r_ready,
    input  logic              r_last,
    output logic              dn_req,
    output logic              dn_rnw,
    output logic [ADDR_W-1:0] dn_addr,
    output logic [CTRL_W-1:0] dn_ctrl,
    input  logic              dn_done
);

    localparam int ENT_W    = ADDR_W + CTRL_W;
    localparam int WR_DEPTH = clamp_accept(WR_ACCEPT);
    localparam int RD_DEPTH = clamp_accept(RD_ACCEPT);

    logic             wr_pend, rd_pend, wr_grant, rd_grant, wr_fin, rd_fin;
    logic [ENT_W-1:0] wr_pdata, rd_pdata, dn_ent;
    logic             b_hs, r_end_hs;

    assign b_hs     = b_valid && b_ready;
    assign r_end_hs = r_valid && r_ready && r_last;

    acc_path #(.DEPTH(WR_DEPTH), .ENT_W(ENT_W)) u_wr_path (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (aw_valid),
        .in_ready   (aw_ready),
        .in_data    ({aw_addr, aw_ctrl}),
        .rsp_hs     (b_hs),
        .pend_valid (wr_pend),
        .pend_data  (wr_pdata),
        .grant      (wr_grant),
        .fin        (wr_fin)
    );

    acc_path #(.DEPTH(RD_DEPTH), .ENT_W(ENT_W)) u_rd_path (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (ar_valid),
        .in_ready   (ar_ready),
        .in_data    ({ar_addr, ar_ctrl}),
        .rsp_hs     (r_end_hs),
        .pend_valid (rd_pend),
        .pend_data  (rd_pdata),
        .grant      (rd_grant),
        .fin        (rd_fin)
    );

    acc_issue_arb #(.ENT_W(ENT_W)) u_arb (
        .clk      (clk),
        .rst      (rst),
        .wr_pend  (wr_pend),
        .wr_data  (wr_pdata),
        .rd_pend  (rd_pend),
        .rd_data  (rd_pdata),
        .dn_done  (dn_done),
        .wr_grant (wr_grant),
        .rd_grant (rd_grant),
        .wr_fin   (wr_fin),
        .rd_fin   (rd_fin),
        .dn_req   (dn_req),
        .dn_rnw   (dn_rnw),
        .dn_ent   (dn_ent)
    );

    assign {dn_addr, dn_ctrl} = dn_ent;

    // R8: at most one direction is granted in any cycle
    p_one_grant_r8: assert property (@(posedge clk) disable iff (rst)
        !(wr_grant && rd_grant));

endmodule

// File: tb/acc_ctl_top_tb.sv
module acc_ctl_top_tb;

    localparam int ADDR_W = 32;
    localparam int CTRL_W = 8;
    localparam int ENT_W  = ADDR_W + CTRL_W;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              aw_valid = 1'b0, ar_valid = 1'b0;
    logic              aw_ready, ar_ready;
    logic [ADDR_W-1:0] aw_addr = '0, ar_addr = '0, dn_addr;
    logic [CTRL_W-1:0] aw_ctrl = '0, ar_ctrl = '0, dn_ctrl;
    logic              b_valid = 1'b0, b_ready = 1'b0;
    logic              r_valid = 1'b0, r_ready = 1'b0, r_last = 1'b0;
    logic              dn_req, dn_rnw;
    logic              dn_done = 1'b0;

    always #4 clk = ~clk;

    acc_ctl_top #(.WR_ACCEPT(1), .RD_ACCEPT(2), .ADDR_W(ADDR_W), .CTRL_W(CTRL_W)) u_dut (
        .clk(clk), .rst(rst),
        .aw_valid(aw_valid), .aw_ready(aw_ready), .aw_addr(aw_addr), .aw_ctrl(aw_ctrl),
        .ar_valid(ar_valid), .ar_ready(ar_ready), .ar_addr(ar_addr), .ar_ctrl(ar_ctrl),
        .b_valid(b_valid), .b_ready(b_ready),
        .r_valid(r_valid), .r_ready(r_ready), .r_last(r_last),
        .dn_req(dn_req), .dn_rnw(dn_rnw), .dn_addr(dn_addr), .dn_ctrl(dn_ctrl),
        .dn_done(dn_done)
    );

    int n_chk = 0;
    int n_fail = 0;
    int done_cnt = 0;
    int rises = 0;
    int lat = 2;
    bit finished = 1'b0;

    logic [ENT_W-1:0] exp_wr[$];
    logic [ENT_W-1:0] exp_rd[$];
    bit               dir_log[$];

    task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic send_aw(input logic [ADDR_W-1:0] a, input logic [CTRL_W-1:0] c);
        aw_valid = 1'b1; aw_addr = a; aw_ctrl = c;
        exp_wr.push_back({a, c});
        @(negedge clk);
        aw_valid = 1'b0;
    endtask

    task automatic send_ar(input logic [ADDR_W-1:0] a, input logic [CTRL_W-1:0] c);
        ar_valid = 1'b1; ar_addr = a; ar_ctrl = c;
        exp_rd.push_back({a, c});
        @(negedge clk);
        ar_valid = 1'b0;
    endtask

    task automatic send_both(input logic [ADDR_W-1:0] wa, input logic [ADDR_W-1:0] ra);
        aw_valid = 1'b1; aw_addr = wa; aw_ctrl = 8'h11;
        ar_valid = 1'b1; ar_addr = ra; ar_ctrl = 8'h22;
        exp_wr.push_back({wa, 8'h11});
        exp_rd.push_back({ra, 8'h22});
        @(negedge clk);
        aw_valid = 1'b0; ar_valid = 1'b0;
    endtask

    task automatic give_b();
        b_valid = 1'b1; b_ready = 1'b1;
        @(negedge clk);
        b_valid = 1'b0; b_ready = 1'b0;
    endtask

    task automatic give_r(input bit last);
        r_valid = 1'b1; r_ready = 1'b1; r_last = last;
        @(negedge clk);
        r_valid = 1'b0; r_ready = 1'b0; r_last = 1'b0;
    endtask

    task automatic wait_done(input int n);
        while (done_cnt < n) @(negedge clk);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // downstream responder: pulses dn_done 'lat' cycles into each request
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && dn_req) begin
                repeat (lat - 1) @(negedge clk);
                dn_done = 1'b1;
                @(negedge clk);
                dn_done = 1'b0;
                done_cnt++;
            end
        end
    end

    // monitor / scoreboard
    initial begin
        logic             prev_req = 1'b0;
        logic [ENT_W-1:0] prev_ent = '0;
        logic             prev_rnw = 1'b0;
        logic [ENT_W-1:0] want;
        forever begin
            @(negedge clk);
            if (!rst) begin
                if (dn_req && !prev_req) begin
                    rises++;
                    // R6: all earlier requests finished before this one began
                    chk(done_cnt == rises - 1, "R6", 64'(done_cnt), 64'(rises - 1));
                    dir_log.push_back(dn_rnw);
                    if (dn_rnw) begin
                        if (exp_rd.size() == 0) begin
                            chk(1'b0, "R9 unexpected read", 64'(dn_addr), 64'd0);
                        end else begin
                            want = exp_rd.pop_front();
                            // R7 order and R9 payload
                            chk({dn_addr, dn_ctrl} == want, "R7/R9 read",
                                64'({dn_addr, dn_ctrl}), 64'(want));
                        end
                    end else begin
                        if (exp_wr.size() == 0) begin
                            chk(1'b0, "R9 unexpected write", 64'(dn_addr), 64'd0);
                        end else begin
                            want = exp_wr.pop_front();
                            chk({dn_addr, dn_ctrl} == want, "R7/R9 write",
                                64'({dn_addr, dn_ctrl}), 64'(want));
                        end
                    end
                end else if (dn_req && prev_req) begin
                    // R5: held request unchanged
                    chk({dn_addr, dn_ctrl, dn_rnw} == {prev_ent, prev_rnw}, "R5",
                        64'({dn_addr, dn_ctrl}), 64'(prev_ent));
                end
                prev_req = dn_req;
                prev_ent = {dn_addr, dn_ctrl};
                prev_rnw = dn_rnw;
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        chk(aw_ready == 1'b1, "R1 aw_ready", 64'(aw_ready), 64'd1);
        chk(ar_ready == 1'b1, "R1 ar_ready", 64'(ar_ready), 64'd1);
        chk(dn_req == 1'b0, "R1 dn_req", 64'(dn_req), 64'd0);

        // R2: limit 1, needs downstream done and B
        lat = 2;
        send_aw(32'h1000_0000, 8'h01);
        chk(aw_ready == 1'b0, "R2 drop", 64'(aw_ready), 64'd0);
        wait_done(1);
        idle(3);
        chk(aw_ready == 1'b0, "R2 done only", 64'(aw_ready), 64'd0);
        give_b();
        idle(3);
        chk(aw_ready == 1'b1, "R2 released", 64'(aw_ready), 64'd1);

        // R11: response before downstream done
        lat = 6;
        send_aw(32'h2000_0004, 8'h02);
        give_b();
        idle(1);
        chk(aw_ready == 1'b0, "R11 early resp", 64'(aw_ready), 64'd0);
        wait_done(2);
        idle(3);
        chk(aw_ready == 1'b1, "R11 released", 64'(aw_ready), 64'd1);

        // R10: stray response with nothing waiting
        give_b();
        lat = 2;
        send_aw(32'h3000_0008, 8'h03);
        wait_done(3);
        idle(4);
        chk(aw_ready == 1'b0, "R10 stray ignored", 64'(aw_ready), 64'd0);
        give_b();
        idle(3);
        chk(aw_ready == 1'b1, "R10 released", 64'(aw_ready), 64'd1);

        // R3/R4: limit 2 on reads
        lat = 6;
        send_ar(32'h4000_0010, 8'h04);
        chk(ar_ready == 1'b1, "R3 second slot", 64'(ar_ready), 64'd1);
        send_ar(32'h5000_0014, 8'h05);
        chk(ar_ready == 1'b0, "R4 full", 64'(ar_ready), 64'd0);
        wait_done(5);
        idle(3);
        chk(ar_ready == 1'b0, "R4 both done no resp", 64'(ar_ready), 64'd0);
        give_r(1'b0);
        idle(3);
        chk(ar_ready == 1'b0, "R4 non-last beat", 64'(ar_ready), 64'd0);
        give_r(1'b1);
        idle(3);
        chk(ar_ready == 1'b1, "R4 oldest released", 64'(ar_ready), 64'd1);
        give_r(1'b1);
        idle(3);

        // R8: simultaneous arrival, last winner was read -> write first
        lat = 2;
        send_both(32'h6000_0020, 32'h7000_0024);
        wait_done(7);
        give_b();
        give_r(1'b1);
        idle(3);
        // lone write so that write is the latest winner
        send_aw(32'h8000_0028, 8'h06);
        wait_done(8);
        give_b();
        idle(3);
        send_both(32'h9000_002C, 32'hA000_0030);
        wait_done(10);
        give_b();
        give_r(1'b1);
        idle(3);

        chk(dir_log.size() == 10, "R8 request count", 64'(dir_log.size()), 64'd10);
        if (dir_log.size() == 10) begin
            chk(dir_log[5] == 1'b0, "R8 tie1 first write", 64'(dir_log[5]), 64'd0);
            chk(dir_log[6] == 1'b1, "R8 tie1 second read", 64'(dir_log[6]), 64'd1);
            chk(dir_log[8] == 1'b1, "R8 tie2 first read", 64'(dir_log[8]), 64'd1);
            chk(dir_log[9] == 1'b0, "R8 tie2 second write", 64'(dir_log[9]), 64'd0);
        end
        chk(aw_ready && ar_ready, "R4 all released", 64'({aw_ready, ar_ready}), 64'd3);
        chk(exp_wr.size() == 0 && exp_rd.size() == 0, "R9 all issued",
            64'(exp_wr.size() + exp_rd.size()), 64'd0);

        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule